// File: doc/BRIEF.md
# Colour LCD Controller Register Block

This block is the register side of a colour LCD controller. It decodes a 4 KB byte window into word registers: four panel timing words, two frame base addresses (upper and lower panel), a control word, an interrupt mask, raw and masked interrupt status, a write-one-to-clear interrupt clear register, and eight read-only identification words. From the timing words it derives the panel width in pixels and the panel height in lines. From the control word it derives a single run condition and a pixel-depth code. A synthesis parameter selects one of two variants. The variants differ in where the mask and control words sit in the map, and in two of the identification bytes.

A frame-tick sequencer stands in for the end-of-frame event. It has three states. ST_HALT is the stopped state. ST_RUN counts clock cycles. ST_PULSE lasts one cycle and raises the tick. Its transitions are as follows. A control write that turns the run condition on moves any state to ST_RUN with the count cleared (restart). A control write that turns it off moves any state to ST_HALT (stop), and so does the run condition being false (stop). ST_RUN moves to ST_PULSE when the count reaches its last value (expire). ST_PULSE returns to ST_RUN with the count cleared (rearm). Each tick sets two raw status bits. The interrupt output is a level that stays high while any raw status bit is also enabled in the mask. Palette storage and pixel fetch live in other blocks.

Top module: `lcdc_regfile`

## Requirements
- R1: After reset every register reads zero, irq and panel_on are 0, pix_depth is 0, panel_cols is 16 and panel_rows is 1.
- R2: A write to word 0 stores the full word, and panel_cols becomes ((value & 0xFC) + 4) * 4 at the same edge.
- R3: A write to word 1 stores the full word, and panel_rows becomes (value & 0x3FF) + 1 at the same edge.
- R4: Words 2 and 3 (timing), word 4 (upper base) and word 5 (lower base) read back what was written. Word 11 reads the upper base and word 12 reads the lower base.
- R5: With EXT_VARIANT = 0 the control word is word 6 and the mask is word 7. With EXT_VARIANT = 1 the two swap (mask at word 6, control at word 7). Each reads back only its own value.
- R6: Words 0x3F8 to 0x3FF (byte 0xFE0 to 0xFFF) read the identification bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order. On the extended variant the first byte is 0x11 and the third is 0x24.
- R7: panel_on is 1 exactly when control bit 0 (enable) and control bit 11 (power) are both 1. pix_depth equals control bits [3:1].
- R8: irq is high exactly when (raw status & mask) is nonzero. Word 9 reads raw status & mask. Word 8 reads raw status.
- R9: A write to word 10 clears each raw status bit written as 1 and leaves the others.
- R10: While panel_on holds, raw status bits 2 (next base) and 3 (vertical compare) are set TICK_CYCLES edges after the enabling control write, and every TICK_CYCLES edges after that. While panel_on is 0 no tick sets them.
- R11: A control write that keeps or makes panel_on true restarts the tick period from that write.
- R12: Reads of unmapped words (13 to 0x3F7, including the palette range) return zero. Writes to them, and to words 8, 9, 11, 12 and the identification words, change nothing.
- R13: bus_rdata changes only at an edge that samples a read strobe, and then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | ADDR_W-2 | Word address (byte address bits [ADDR_W-1:2]) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq | output | 1 | Level interrupt |
| panel_on | output | 1 | Enable and power both set |
| pix_depth | output | 3 | Pixel depth code from control bits [3:1] |
| panel_cols | output | 11 | Panel width in pixels |
| panel_rows | output | 11 | Panel height in lines |

## Verification
Register writes, the derived panel outputs, panel_on and irq all change at the edge that samples the write strobe. The bench checks them at the next falling edge. Read data appears one edge after the read strobe, so every read task samples at the falling edge after that edge. A tick is due exactly TICK_CYCLES edges after the enabling control write. The bench counts falling edges from the write: it expects irq low at each of the TICK_CYCLES-1 edges before, and high at the due edge. This catches a period that is one cycle off in either direction, as well as a restart that is missed.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int STAT_W       = 5;
    localparam int CTRL_W       = 16;
    localparam int BIT_EN       = 0;
    localparam int BIT_PWR      = 11;
    localparam int BIT_NEXTBASE = 2;
    localparam int BIT_VCMP     = 3;

    typedef enum logic [3:0] {
        SEL_T0    = 4'd0,
        SEL_T1    = 4'd1,
        SEL_T2    = 4'd2,
        SEL_T3    = 4'd3,
        SEL_UPB   = 4'd4,
        SEL_LPB   = 4'd5,
        SEL_MASK  = 4'd6,
        SEL_CTRL  = 4'd7,
        SEL_RAW   = 4'd8,
        SEL_MSTAT = 4'd9,
        SEL_CLR   = 4'd10,
        SEL_UPCUR = 4'd11,
        SEL_LPCUR = 4'd12,
        SEL_ID    = 4'd13,
        SEL_NONE  = 4'd14
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PULSE = 2'd2
    } tick_state_e;

    function automatic logic [7:0] id_byte(input logic ext, input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = ext ? 8'h11 : 8'h10;
            3'd1:    b = 8'h11;
            3'd2:    b = ext ? 8'h24 : 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdc_addr_decode.sv
module lcdc_addr_decode
    import lcdc_pkg::*;
#(
    parameter int WORD_W      = 10,
    parameter int EXT_VARIANT = 0
) (
    input  logic [WORD_W-1:0] word_addr,
    output reg_sel_e          sel,
    output logic [2:0]        id_idx
);

    logic [WORD_W-1:0] mask_off;
    logic [WORD_W-1:0] ctrl_off;

    generate
        if (EXT_VARIANT != 0) begin : g_ext_map
            assign mask_off = WORD_W'(6);
            assign ctrl_off = WORD_W'(7);
        end else begin : g_base_map
            assign mask_off = WORD_W'(7);
            assign ctrl_off = WORD_W'(6);
        end
    endgenerate

    always_comb begin
        id_idx = word_addr[2:0];
        sel    = SEL_NONE;
        if (&word_addr[WORD_W-1:3]) begin
            sel = SEL_ID;
        end else if (word_addr == mask_off) begin
            sel = SEL_MASK;
        end else if (word_addr == ctrl_off) begin
            sel = SEL_CTRL;
        end else begin
            case (word_addr)
                WORD_W'(0):  sel = SEL_T0;
                WORD_W'(1):  sel = SEL_T1;
                WORD_W'(2):  sel = SEL_T2;
                WORD_W'(3):  sel = SEL_T3;
                WORD_W'(4):  sel = SEL_UPB;
                WORD_W'(5):  sel = SEL_LPB;
                WORD_W'(8):  sel = SEL_RAW;
                WORD_W'(9):  sel = SEL_MSTAT;
                WORD_W'(10): sel = SEL_CLR;
                WORD_W'(11): sel = SEL_UPCUR;
                WORD_W'(12): sel = SEL_LPCUR;
                default:     sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lcdc_tick_fsm.sv
module lcdc_tick_fsm
    import lcdc_pkg::*;
#(
    parameter int TICK_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_wr_on,
    input  logic run_on,
    output logic fire
);

    localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 2);

    tick_state_e       st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HALT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_HALT: begin
                st_d = ST_HALT;
            end
            ST_RUN: begin
                if (cnt_q == LAST) begin
                    st_d = ST_PULSE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_PULSE: begin
                st_d  = ST_RUN;
                cnt_d = '0;
            end
            default: begin
                st_d = ST_HALT;
            end
        endcase
        if (ctrl_wr) begin
            if (ctrl_wr_on) begin
                st_d  = ST_RUN;
                cnt_d = '0;
            end else begin
                st_d = ST_HALT;
            end
        end else if (!run_on) begin
            st_d = ST_HALT;
        end
    end

    // outputs
    always_comb begin
        fire = (st_q == ST_PULSE);
    end

    // R10
    tick_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_on && !ctrl_wr) |=> !fire);

    // R11
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wr_on) |=> (st_q == ST_RUN && cnt_q == '0));

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (cnt_q <= LAST));

endmodule

// File: rtl/lcdc_irq_unit.sv
module lcdc_irq_unit
    import lcdc_pkg::*;
#(
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_wr,
    input  logic          clr_wr,
    input  logic [SW-1:0] wdata,
    input  logic          fire,
    output logic [SW-1:0] raw_q,
    output logic [SW-1:0] mask_q,
    output logic          irq
);

    localparam logic [SW-1:0] TICK_BITS =
        SW'((1 << BIT_NEXTBASE) | (1 << BIT_VCMP));

    logic [SW-1:0] clr_bits;
    logic [SW-1:0] set_bits;

    always_comb begin
        clr_bits = clr_wr ? wdata : '0;
        set_bits = fire ? TICK_BITS : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | set_bits;
            if (mask_wr) begin
                mask_q <= wdata;
            end
        end
    end

    always_comb begin
        irq = |(raw_q & mask_q);
    end

    // R9
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && (&wdata) && !fire) |=> (raw_q == '0));

    // R10
    fire_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (raw_q[BIT_NEXTBASE] && raw_q[BIT_VCMP]));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
    import lcdc_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int EXT_VARIANT = 0,
    parameter int TICK_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:2] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              panel_on,
    output logic [2:0]        pix_depth,
    output logic [10:0]       panel_cols,
    output logic [10:0]       panel_rows
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int N_TIM  = 4;

    reg_sel_e                      sel;
    logic [2:0]                    id_idx;
    logic                          wr_go, rd_go;
    logic                          ctrl_wr, ctrl_wr_on;
    logic                          fire;
    logic [N_TIM-1:0][DATA_W-1:0]  tim_q;
    logic [DATA_W-1:0]             upb_q, lpb_q;
    logic [CTRL_W-1:0]             ctrl_q;
    logic [STAT_W-1:0]             raw_q, mask_q;
    logic [DATA_W-1:0]             rd_d;

    lcdc_addr_decode #(
        .WORD_W      (WORD_W),
        .EXT_VARIANT (EXT_VARIANT)
    ) dec_i (
        .word_addr (bus_addr),
        .sel       (sel),
        .id_idx    (id_idx)
    );

    always_comb begin
        wr_go      = bus_sel && bus_wr;
        rd_go      = bus_sel && !bus_wr;
        ctrl_wr    = wr_go && (sel == SEL_CTRL);
        ctrl_wr_on = bus_wdata[BIT_EN] && bus_wdata[BIT_PWR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q  <= '0;
            upb_q  <= '0;
            lpb_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_go) begin
            for (int i = 0; i < N_TIM; i++) begin
                if (sel == reg_sel_e'(4'(i))) begin
                    tim_q[i] <= bus_wdata;
                end
            end
            if (sel == SEL_UPB)  upb_q  <= bus_wdata;
            if (sel == SEL_LPB)  lpb_q  <= bus_wdata;
            if (sel == SEL_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    lcdc_tick_fsm #(
        .TICK_CYCLES (TICK_CYCLES)
    ) tick_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wr_on (ctrl_wr_on),
        .run_on     (panel_on),
        .fire       (fire)
    );

    lcdc_irq_unit #(
        .SW (STAT_W)
    ) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (wr_go && (sel == SEL_MASK)),
        .clr_wr  (wr_go && (sel == SEL_CLR)),
        .wdata   (bus_wdata[STAT_W-1:0]),
        .fire    (fire),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

    always_comb begin
        panel_on   = ctrl_q[BIT_EN] && ctrl_q[BIT_PWR];
        pix_depth  = ctrl_q[3:1];
        panel_cols = {7'(tim_q[0][7:2]) + 7'd1, 4'b0000};
        panel_rows = {1'b0, tim_q[1][9:0]} + 11'd1;
    end

    always_comb begin
        unique case (sel)
            SEL_T0, SEL_T1, SEL_T2, SEL_T3: rd_d = tim_q[sel[1:0]];
            SEL_UPB, SEL_UPCUR:             rd_d = upb_q;
            SEL_LPB, SEL_LPCUR:             rd_d = lpb_q;
            SEL_MASK:                       rd_d = DATA_W'(mask_q);
            SEL_CTRL:                       rd_d = DATA_W'(ctrl_q);
            SEL_RAW:                        rd_d = DATA_W'(raw_q);
            SEL_MSTAT:                      rd_d = DATA_W'(raw_q & mask_q);
            SEL_ID:                         rd_d = DATA_W'(id_byte(EXT_VARIANT != 0, id_idx));
            default:                        rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_go) begin
            bus_rdata <= rd_d;
        end
    end

    // R12
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && (sel == SEL_NONE)) |=>
            ($stable(ctrl_q) && $stable(tim_q) && $stable(upb_q) && $stable(lpb_q) && $stable(mask_q)));

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(bus_rdata));

endmodule

// File: tb/lcdc_regfile_tb_top.sv
`timescale 1ns/1ps
module lcdc_regfile_tb_top;

    localparam int TICK_P = 16;
    localparam int O_CTRL_B = 6, O_MASK_B = 7;
    localparam int O_CTRL_X = 7, O_MASK_X = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [9:0]  addr_b = '0, addr_x = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_b, rdata_x;
    logic        irq_b, irq_x, on_b, on_x;
    logic [2:0]  dep_b, dep_x;
    logic [10:0] cols_b, cols_x, rows_b, rows_x;

    int vecs = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lcdc_regfile #(.ADDR_W(12), .DATA_W(32), .EXT_VARIANT(0), .TICK_CYCLES(TICK_P)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr_b),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .irq(irq_b), .panel_on(on_b),
        .pix_depth(dep_b), .panel_cols(cols_b), .panel_rows(rows_b));

    lcdc_regfile #(.ADDR_W(12), .DATA_W(32), .EXT_VARIANT(1), .TICK_CYCLES(TICK_P)) ext_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr_x),
        .bus_wdata(wdata), .bus_rdata(rdata_x), .irq(irq_x), .panel_on(on_x),
        .pix_depth(dep_x), .panel_cols(cols_x), .panel_rows(rows_x));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr2(input int ob, input int ox, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr_b = 10'(ob); addr_x = 10'(ox); wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd2(input int ob, input int ox, output logic [31:0] vb, output logic [31:0] vx);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr_b = 10'(ob); addr_x = 10'(ox);
        @(negedge clk);
        sel = 1'b0;
        vb = rdata_b;
        vx = rdata_x;
    endtask

    task automatic rd_chk(input string req, input int ob, input int ox,
                          input logic [31:0] eb, input logic [31:0] ex);
        logic [31:0] vb, vx;
        rd2(ob, ox, vb, vx);
        chk({req, " base"}, vb, eb);
        chk({req, " ext"}, vx, ex);
    endtask

    // expects irq low for TICK_P-1 falling edges, then high
    task automatic tick_due(input string req);
        for (int k = 1; k < TICK_P; k++) begin
            @(negedge clk);
            chk({req, " early base"}, 32'(irq_b), 32'd0);
            chk({req, " early ext"}, 32'(irq_x), 32'd0);
        end
        @(negedge clk);
        chk({req, " due base"}, 32'(irq_b), 32'd1);
        chk({req, " due ext"}, 32'(irq_x), 32'd1);
    endtask

    initial begin
        logic [7:0] idb [8];
        logic [7:0] idx [8];
        logic [31:0] vb, vx, cv;
        idb = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        idx = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {30'd0, irq_b, irq_x}, 32'd0);
        chk("R1 on", {30'd0, on_b, on_x}, 32'd0);
        chk("R1 depth", {26'd0, dep_b, dep_x}, 32'd0);
        chk("R1 cols", {10'd0, cols_b, cols_x}, {10'd0, 11'd16, 11'd16});
        chk("R1 rows", {10'd0, rows_b, rows_x}, {10'd0, 11'd1, 11'd1});
        for (int w = 0; w < 13; w++) rd_chk("R1 reg", w, w, 32'd0, 32'd0);

        // R2 column sweep
        for (int k = 0; k < 256; k++) begin
            wr2(0, 0, 32'h5A00_0000 | 32'(k));
            chk("R2 cols base", 32'(cols_b), ((32'(k) & 32'hFC) + 32'd4) * 32'd4);
            chk("R2 cols ext", 32'(cols_x), ((32'(k) & 32'hFC) + 32'd4) * 32'd4);
        end
        rd_chk("R2 readback", 0, 0, 32'h5A00_00FF, 32'h5A00_00FF);

        // R3 row sweep
        for (int k = 0; k < 1024; k++) begin
            wr2(1, 1, 32'hFFFF_FC00 | 32'(k));
            chk("R3 rows base", 32'(rows_b), 32'(k) + 32'd1);
            chk("R3 rows ext", 32'(rows_x), 32'(k) + 32'd1);
        end
        rd_chk("R3 readback", 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R4 plain words and current-address aliases
        wr2(2, 2, 32'h1234_5678);
        wr2(3, 3, 32'h9ABC_DEF0);
        wr2(4, 4, 32'h0010_0000);
        wr2(5, 5, 32'h0020_0040);
        rd_chk("R4 t2", 2, 2, 32'h1234_5678, 32'h1234_5678);
        rd_chk("R4 t3", 3, 3, 32'h9ABC_DEF0, 32'h9ABC_DEF0);
        rd_chk("R4 upper", 4, 4, 32'h0010_0000, 32'h0010_0000);
        rd_chk("R4 lower", 5, 5, 32'h0020_0040, 32'h0020_0040);
        rd_chk("R4 upper cur", 11, 11, 32'h0010_0000, 32'h0010_0000);
        rd_chk("R4 lower cur", 12, 12, 32'h0020_0040, 32'h0020_0040);

        // R13 read data holds across idle cycles and writes
        rd2(2, 2, vb, vx);
        repeat (3) @(negedge clk);
        chk("R13 hold idle", rdata_b, 32'h1234_5678);
        wr2(3, 3, 32'h0BAD_F00D);
        chk("R13 hold write", rdata_x, 32'h1234_5678);

        // R5 and R7 control sweep at swapped offsets
        for (int k = 0; k < 32; k++) begin
            cv = 32'(k & 1) | (32'((k >> 1) & 1) << 11) | (32'((k >> 2) & 7) << 1);
            wr2(O_CTRL_B, O_CTRL_X, cv);
            chk("R7 on base", 32'(on_b), 32'((k & 3) == 3));
            chk("R7 on ext", 32'(on_x), 32'((k & 3) == 3));
            chk("R7 depth base", 32'(dep_b), 32'((k >> 2) & 7));
            chk("R7 depth ext", 32'(dep_x), 32'((k >> 2) & 7));
            rd_chk("R5 ctrl", O_CTRL_B, O_CTRL_X, cv, cv);
            rd_chk("R5 mask untouched", O_MASK_B, O_MASK_X, 32'd0, 32'd0);
        end
        wr2(O_CTRL_B, O_CTRL_X, 32'd0);
        wr2(10, 10, 32'h1F);
        wr2(O_MASK_B, O_MASK_X, 32'hFFFF_FF13);
        rd_chk("R5 mask", O_MASK_B, O_MASK_X, 32'h13, 32'h13);
        rd_chk("R5 ctrl untouched", O_CTRL_B, O_CTRL_X, 32'd0, 32'd0);

        // R6 identification bytes
        for (int i = 0; i < 8; i++)
            rd_chk("R6 id", 10'h3F8 + i, 10'h3F8 + i, 32'(idb[i]), 32'(idx[i]));

        // R12 unmapped and read-only words
        wr2(0, 0, 32'h0000_0044);
        for (int i = 0; i < 5; i++) begin
            int w;
            w = (i == 0) ? 13 : (i == 1) ? 15 : (i == 2) ? 10'h80 : (i == 3) ? 10'h3F7 : 10'h3FA;
            wr2(w, w, 32'hFFFF_FFFF);
            rd_chk("R12 unmapped", w, w,
                   (i == 4) ? 32'(idb[2]) : 32'd0, (i == 4) ? 32'(idx[2]) : 32'd0);
        end
        wr2(8, 8, 32'hFFFF_FFFF);
        wr2(9, 9, 32'hFFFF_FFFF);
        wr2(11, 11, 32'hFFFF_FFFF);
        rd_chk("R12 t0 kept", 0, 0, 32'h44, 32'h44);
        rd_chk("R12 ctrl kept", O_CTRL_B, O_CTRL_X, 32'd0, 32'd0);
        rd_chk("R12 raw kept", 8, 8, 32'd0, 32'd0);
        rd_chk("R12 upper kept", 4, 4, 32'h0010_0000, 32'h0010_0000);
        chk("R12 irq", {30'd0, irq_b, irq_x}, 32'd0);

        // R10 periodic tick
        wr2(O_MASK_B, O_MASK_X, 32'h0C);
        wr2(O_CTRL_B, O_CTRL_X, 32'h801);
        tick_due("R10 first");
        rd_chk("R10 raw", 8, 8, 32'h0C, 32'h0C);

        // R9 write-one-to-clear
        wr2(10, 10, 32'h4);
        rd_chk("R9 partial raw", 8, 8, 32'h8, 32'h8);
        rd_chk("R8 masked", 9, 9, 32'h8, 32'h8);
        chk("R8 irq after partial", {30'd0, irq_b, irq_x}, 32'd3);
        wr2(10, 10, 32'h8);
        chk("R9 irq cleared", {30'd0, irq_b, irq_x}, 32'd0);
        rd_chk("R9 raw clear", 8, 8, 32'd0, 32'd0);
        // the next tick is measured from the enabling write; clear and re-arm
        wr2(O_CTRL_B, O_CTRL_X, 32'd0);
        wr2(10, 10, 32'h1F);

        // R10 no tick while disabled
        wr2(O_CTRL_B, O_CTRL_X, 32'h001);
        for (int k = 0; k < 3 * TICK_P; k++) begin
            @(negedge clk);
            chk("R10 enable only", {30'd0, irq_b, irq_x}, 32'd0);
        end
        wr2(O_CTRL_B, O_CTRL_X, 32'h800);
        for (int k = 0; k < 3 * TICK_P; k++) begin
            @(negedge clk);
            chk("R10 power only", {30'd0, irq_b, irq_x}, 32'd0);
        end
        rd_chk("R10 raw idle", 8, 8, 32'd0, 32'd0);

        // R11 restart by control write
        wr2(O_CTRL_B, O_CTRL_X, 32'h801);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R11 pre", {30'd0, irq_b, irq_x}, 32'd0);
        end
        wr2(O_CTRL_B, O_CTRL_X, 32'h805);
        tick_due("R11 restart");
        wr2(O_CTRL_B, O_CTRL_X, 32'd0);

        // R8 mask sweep with raw = 0xC
        for (int m = 0; m < 32; m++) begin
            wr2(O_MASK_B, O_MASK_X, 32'(m));
            chk("R8 irq base", 32'(irq_b), 32'((m & 12) != 0));
            chk("R8 irq ext", 32'(irq_x), 32'((m & 12) != 0));
            rd_chk("R8 masked", 9, 9, 32'(m & 12), 32'(m & 12));
        end
        rd_chk("R8 raw", 8, 8, 32'h0C, 32'h0C);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

endmodule